// File: doc/BRIEF.md
# Pi/4-shift QPSK burst transmit controller

This block turns a serial transmit bit stream into a sequence of differential pi/4-shift QPSK phase states for a baseband shaping filter that follows it. Bits are taken in pairs. Each pair moves an absolute phase index by an odd multiple of 45 degrees, so the index has eight values. A window input marks each burst. While the window is open the block emits symbols. Around each burst it drives a burst-window flag and a linear envelope ramp, two symbols long on each side, that the filter or DAC stage uses to scale the output.

The bit clock has two sources, picked by a mode pin. In divide mode the fast system clock is divided by `DIV_RATIO` (ten by default) to make the bit clock. In pass mode a bit clock that the data source supplies, synchronous to the system clock, is used as it is. In both modes the bit clock in use is driven on an output pin, so the data source can launch its bits from it. All outputs go through an alignment delay of `DLY_QSYM` quarter-symbols (6.25 symbols, which is 125 fast cycles by default).

The input is a free-running paced stream with no back-pressure. A bit is taken at every rising bit-clock edge whether or not anything downstream is ready. The output is a paced stream: `sym_valid` is a one-cycle strobe with no ready, so the filter must accept every symbol in the cycle it appears.

Top module: `qpsk_burst_tx`

## Requirements
- R1: With `div_mode`=1, `bitclk_out` has a period of `DIV_RATIO` system clocks. It is high for the first `DIV_RATIO/2` of them and low for the rest.
- R2: With `div_mode`=0, `bitclk_out` equals `bitclk_in` in the same cycle.
- R3: `txd` and `win` are sampled at the clock edge that ends the first cycle in which the selected bit clock is high after being low.
- R4: Bits sampled with `win`=1 are paired in arrival order, counting from the first bit of the window, and the first bit of a pair is the MSB. A bit left unpaired when the window closes is dropped. Bits sampled with `win`=0 produce no symbol.
- R5: Each pair adds a step to the 3-bit phase index (unit 45 degrees, modulo 8): 00 adds 1, 01 adds 3, 11 adds 5, 10 adds 7. `phase` carries the new index in the cycle that `sym_valid` is 1.
- R6: The phase index returns to 0 when a window opens, so the first symbol of a burst equals the step of its first pair.
- R7: `burst` rises exactly DLY_CYC = DLY_QSYM*2*DIV_RATIO/4 clock edges after the edge that samples the first window-high bit. Each `sym_valid` pulse comes DLY_CYC edges after the edge that samples the second bit of its pair.
- R8: With RAMP_CYC = RAMP_SYMS*2*DIV_RATIO, `env` in the k-th cycle after `burst` rises (k from 0) is floor(k*2^LVL_W/RAMP_CYC) for k < RAMP_CYC. After that it holds at 2^LVL_W-1.
- R9: In the k-th cycle after DLY_CYC edges past the edge that samples the window closing, `env` is 2^LVL_W-1 minus floor(k*2^LVL_W/RAMP_CYC), with `burst` still 1. `burst` falls when k reaches RAMP_CYC.
- R10: Whenever `burst` is 0, `env` is 0 and `sym_valid` is 0.
- R11: While `rst_n` is low, `sym_valid`, `phase`, `env` and `burst` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock, ten times the bit rate by default |
| rst_n | input | 1 | Active-low reset |
| div_mode | input | 1 | 1: divide the system clock; 0: use `bitclk_in` |
| bitclk_in | input | 1 | External bit clock, synchronous to `clk` |
| txd | input | 1 | Serial transmit data |
| win | input | 1 | Burst window request |
| bitclk_out | output | 1 | Bit clock in use |
| sym_valid | output | 1 | One-cycle strobe for a new symbol |
| phase | output | 3 | Absolute phase index, 45-degree units |
| env | output | LVL_W | Envelope level |
| burst | output | 1 | Burst window, aligned to the output |

## Verification
The bench builds the block with its defaults: DIV_RATIO=10, RAMP_SYMS=2, DLY_QSYM=25 and LVL_W=3. That gives 20-cycle symbols, 40-cycle ramps and a 125-cycle alignment delay. These values are small enough that a burst of a few symbols covers a full ramp-up, a held plateau, a full ramp-down and a flush of the delay line. They also let every envelope step be compared cycle by cycle against the floor formula. The 125-cycle delay is not a multiple of the 20-cycle symbol, so an alignment error of a whole symbol or a whole bit shows up in the measured latency. Pass mode is driven with a 10-cycle external bit clock so that both clock sources feed the same pairing and phase checks.

// File: rtl/qtx_pkg.sv
package qtx_pkg;

  localparam int PH_W = 3;

  typedef enum logic [1:0] {
    RS_IDLE = 2'd0,
    RS_UP   = 2'd1,
    RS_FULL = 2'd2,
    RS_DOWN = 2'd3
  } ramp_st_t;

  // phase advance in 45-degree units for one dibit (first bit is MSB)
  function automatic logic [PH_W-1:0] dibit_step(input logic [1:0] d);
    case (d)
      2'b00:   return 3'd1;
      2'b01:   return 3'd3;
      2'b11:   return 3'd5;
      default: return 3'd7;
    endcase
  endfunction

endpackage

// File: rtl/qtx_bitclk.sv
module qtx_bitclk #(
  parameter int DIV_RATIO = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic div_mode,
  input  logic bitclk_in,
  output logic bclk,
  output logic stb
);
  localparam int CW   = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
  localparam int HALF = DIV_RATIO / 2;

  logic [CW-1:0] cnt;
  logic          lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      lvl_q <= 1'b1;
    end else begin
      cnt   <= (cnt == CW'(DIV_RATIO - 1)) ? '0 : cnt + 1'b1;
      lvl_q <= bclk;
    end
  end

  assign bclk = div_mode ? (cnt < CW'(HALF)) : bitclk_in;
  assign stb  = bclk & ~lvl_q;

endmodule

// File: rtl/qtx_mapper.sv
module qtx_mapper
  import qtx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stb,
  input  logic            txd,
  input  logic            win,
  output logic            sym_vld,
  output logic [PH_W-1:0] phase,
  output logic            win_open,
  output logic            win_close
);
  logic win_q, half, first;

  assign win_open  = stb &  win & ~win_q;
  assign win_close = stb & ~win &  win_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q   <= 1'b0;
      half    <= 1'b0;
      first   <= 1'b0;
      phase   <= '0;
      sym_vld <= 1'b0;
    end else begin
      sym_vld <= 1'b0;
      if (stb) begin
        win_q <= win;
        if (!win) begin
          half <= 1'b0;
        end else if (!win_q) begin
          phase <= '0;
          first <= txd;
          half  <= 1'b1;
        end else if (half) begin
          phase   <= phase + dibit_step({first, txd});
          sym_vld <= 1'b1;
          half    <= 1'b0;
        end else begin
          first <= txd;
          half  <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/qtx_ramp.sv
module qtx_ramp
  import qtx_pkg::*;
#(
  parameter int RAMP_CYC = 40,
  parameter int LVL_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  output logic [LVL_W-1:0] env,
  output logic             active
);
  localparam int CW   = (RAMP_CYC > 1) ? $clog2(RAMP_CYC) : 1;
  localparam int PW   = CW + LVL_W + 1;
  localparam int MAXL = (1 << LVL_W) - 1;

  ramp_st_t       st;
  logic [CW-1:0]  cnt;
  logic [PW-1:0]  scaled;
  logic           last;

  assign last = (cnt == CW'(RAMP_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= RS_IDLE;
      cnt <= '0;
    end else if (start) begin
      st  <= RS_UP;
      cnt <= '0;
    end else if (stop) begin
      st  <= RS_DOWN;
      cnt <= '0;
    end else begin
      case (st)
        RS_UP: begin
          cnt <= last ? '0 : cnt + 1'b1;
          if (last) st <= RS_FULL;
        end
        RS_DOWN: begin
          cnt <= last ? '0 : cnt + 1'b1;
          if (last) st <= RS_IDLE;
        end
        default: cnt <= '0;
      endcase
    end
  end

  assign scaled = (PW'(cnt) << LVL_W) / PW'(RAMP_CYC);

  always_comb begin
    case (st)
      RS_UP:   env = LVL_W'(scaled);
      RS_FULL: env = LVL_W'(MAXL);
      RS_DOWN: env = LVL_W'(MAXL) - LVL_W'(scaled);
      default: env = '0;
    endcase
  end

  assign active = (st != RS_IDLE);

endmodule

// File: rtl/qtx_delay.sv
module qtx_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 125
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign q = d;
    end else begin : g_pipe
      logic [W-1:0] stg [DEPTH];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
        end else begin
          stg[0] <= d;
          for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
        end
      end
      assign q = stg[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/qpsk_burst_tx.sv
module qpsk_burst_tx
  import qtx_pkg::*;
#(
  parameter int DIV_RATIO = 10,
  parameter int RAMP_SYMS = 2,
  parameter int DLY_QSYM  = 25,
  parameter int LVL_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_mode,
  input  logic             bitclk_in,
  input  logic             txd,
  input  logic             win,
  output logic             bitclk_out,
  output logic             sym_valid,
  output logic [2:0]       phase,
  output logic [LVL_W-1:0] env,
  output logic             burst
);
  localparam int SYM_CYC  = 2 * DIV_RATIO;
  localparam int RAMP_CYC = RAMP_SYMS * SYM_CYC;
  localparam int DLY_CYC  = DLY_QSYM * SYM_CYC / 4;

  typedef struct packed {
    logic             vld;
    logic [PH_W-1:0]  ph;
    logic [LVL_W-1:0] lvl;
    logic             act;
  } tx_out_t;

  localparam int OW = $bits(tx_out_t);

  logic            stb, m_vld, w_open, w_close, r_act;
  logic [PH_W-1:0] m_ph;
  logic [LVL_W-1:0] r_env;
  tx_out_t         core_o, dly_o;

  qtx_bitclk #(.DIV_RATIO(DIV_RATIO)) u_clk (
    .clk(clk), .rst_n(rst_n), .div_mode(div_mode), .bitclk_in(bitclk_in),
    .bclk(bitclk_out), .stb(stb)
  );

  qtx_mapper u_map (
    .clk(clk), .rst_n(rst_n), .stb(stb), .txd(txd), .win(win),
    .sym_vld(m_vld), .phase(m_ph), .win_open(w_open), .win_close(w_close)
  );

  qtx_ramp #(.RAMP_CYC(RAMP_CYC), .LVL_W(LVL_W)) u_ramp (
    .clk(clk), .rst_n(rst_n), .start(w_open), .stop(w_close),
    .env(r_env), .active(r_act)
  );

  assign core_o = '{vld: m_vld, ph: m_ph, lvl: r_env, act: r_act};

  qtx_delay #(.W(OW), .DEPTH(DLY_CYC)) u_dly (
    .clk(clk), .rst_n(rst_n), .d(core_o), .q(dly_o)
  );

  assign sym_valid = dly_o.vld;
  assign phase     = dly_o.ph;
  assign env       = dly_o.lvl;
  assign burst     = dly_o.act;

endmodule

// File: rtl/qpsk_burst_tx_chk.sv
module qpsk_burst_tx_chk #(
  parameter int DIV_RATIO = 10,
  parameter int RAMP_CYC  = 40,
  parameter int LVL_W     = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             div_mode,
  input logic             bitclk_out,
  input logic             sym_valid,
  input logic [2:0]       phase,
  input logic [LVL_W-1:0] env,
  input logic             burst
);
  localparam int MAXL    = (1 << LVL_W) - 1;
  localparam int FULL_AT = (MAXL * RAMP_CYC + MAXL) / (MAXL + 1);

  logic        bc_d, seen, burst_d;
  logic [15:0] per, kcnt;
  logic [2:0]  last_ph;
  logic        bc_rise;

  assign bc_rise = bitclk_out & ~bc_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bc_d    <= 1'b1;
      seen    <= 1'b0;
      per     <= '0;
      burst_d <= 1'b0;
      kcnt    <= '0;
      last_ph <= '0;
    end else begin
      bc_d    <= bitclk_out;
      burst_d <= burst;
      if (bc_rise) begin
        per  <= 16'd1;
        seen <= 1'b1;
      end else if (per != 16'hFFFF) begin
        per <= per + 1'b1;
      end
      if (burst && !burst_d) kcnt <= 16'd1;
      else if (kcnt != 16'hFFFF) kcnt <= kcnt + 1'b1;
      if (burst && !burst_d) last_ph <= '0;
      else if (sym_valid) last_ph <= phase;
    end
  end

  AST_DIV_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (div_mode && bc_rise && seen) |-> (per == 16'(DIV_RATIO))); // R1

  AST_ENV_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !burst |-> (env == '0)); // R10

  AST_SYM_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |-> burst); // R10

  AST_PHASE_ODD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |-> (phase[0] != last_ph[0])); // R5

  AST_RAMP_FULL_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    (burst && env == LVL_W'(MAXL)) |-> (burst_d && kcnt >= 16'(FULL_AT))); // R8

endmodule

bind qpsk_burst_tx qpsk_burst_tx_chk #(
  .DIV_RATIO(DIV_RATIO), .RAMP_CYC(RAMP_CYC), .LVL_W(LVL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .div_mode(div_mode), .bitclk_out(bitclk_out),
  .sym_valid(sym_valid), .phase(phase), .env(env), .burst(burst)
);

// File: tb/qpsk_burst_tx_test.sv
`timescale 1ns/1ps
module qpsk_burst_tx_test;
  localparam int DIV  = 10;
  localparam int DLY  = 25 * 2 * DIV / 4;
  localparam int RAMP = 2 * 2 * DIV;
  localparam int LVLS = 8;
  localparam int LOGN = 4096;
  localparam int WD   = 200000;

  // {dibit, expected phase after the step}
  localparam logic [4:0] VEC [8] = '{
    5'b00_001, 5'b01_100, 5'b11_001, 5'b10_000,
    5'b11_101, 5'b11_010, 5'b00_011, 5'b01_110
  };

  logic clk = 0, rst_n = 0, div_mode = 1, bitclk_in = 0, txd = 0, win = 0;
  logic bitclk_out, sym_valid, burst;
  logic [2:0] phase, env;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0, gen_on = 0;
  int gcnt = 0;

  int  e_rise, e_fall, rise_obs, fall_obs, last_rise_e, last_period;
  int  nsym = 0, ngot = 0;
  int  sym_e [64];
  int  got_ph [64];
  logic [2:0] env_log [LOGN];
  bit  burst_log [LOGN];
  bit  bc_p = 1, win_p = 0, half = 0, burst_p = 0, rise_seen = 0;

  qpsk_burst_tx uut (
    .clk(clk), .rst_n(rst_n), .div_mode(div_mode), .bitclk_in(bitclk_in),
    .txd(txd), .win(win), .bitclk_out(bitclk_out), .sym_valid(sym_valid),
    .phase(phase), .env(env), .burst(burst)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #1;
    if (gen_on) begin
      gcnt = (gcnt + 1) % 10;
      bitclk_in = (gcnt < 5);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: input sampling points and output log
  always @(negedge clk) begin
    if (rst_n) begin
      if (bitclk_out && !bc_p) begin
        if (rise_seen) last_period = cyc + 1 - last_rise_e;
        last_rise_e = cyc + 1;
        rise_seen = 1;
        if (win && !win_p) begin
          e_rise = cyc + 1;
          half = 1;
        end else if (win) begin
          if (half) begin
            if (nsym < 64) sym_e[nsym] = cyc + 1;
            nsym++;
            half = 0;
          end else half = 1;
        end
        if (!win && win_p) e_fall = cyc + 1;
        if (!win) half = 0;
        win_p = win;
      end
      if (sym_valid) begin
        if (ngot < 64 && ngot < nsym) begin
          chk(cyc == sym_e[ngot] + DLY, "R3 R7 symbol latency", cyc - sym_e[ngot], DLY);
          got_ph[ngot] = int'(phase);
        end else chk(0, "R4 unexpected symbol", ngot, nsym);
        ngot++;
      end
      if (burst && !burst_p) rise_obs = cyc;
      if (!burst && burst_p) fall_obs = cyc;
      burst_p = burst;
    end
    bc_p = bitclk_out;
    if (cyc < LOGN) begin
      env_log[cyc] = env;
      burst_log[cyc] = burst;
    end
  end

  task automatic send_bit(input logic b, input logic w);
    logic p;
    p = bitclk_out;
    forever begin
      @(negedge clk);
      if (p && !bitclk_out) break;
      p = bitclk_out;
    end
    txd = b;
    win = w;
  endtask

  task automatic flush();
    repeat (DLY + RAMP + 60) @(negedge clk);
  endtask

  task automatic check_envelope();
    for (int k = 0; k < RAMP + 4; k++) begin
      int c, e;
      c = e_rise + DLY + k;
      e = (k < RAMP) ? (k * LVLS) / RAMP : LVLS - 1;
      chk(env_log[c] == 3'(e), "R8 ramp-up level", int'(env_log[c]), e);
    end
    for (int k = 0; k < RAMP; k++) begin
      int c, e;
      c = e_fall + DLY + k;
      e = LVLS - 1 - (k * LVLS) / RAMP;
      chk(env_log[c] == 3'(e) && burst_log[c], "R9 ramp-down level", int'(env_log[c]), e);
    end
    chk(fall_obs == e_fall + DLY + RAMP, "R9 burst end", fall_obs - e_fall, DLY + RAMP);
    chk(env_log[fall_obs] == 0, "R10 idle level", int'(env_log[fall_obs]), 0);
  endtask

  initial begin
    int base, highs;
    repeat (4) @(negedge clk);
    chk(sym_valid == 0 && burst == 0, "R11 reset flags", {sym_valid, burst}, 0);
    chk(env == 0 && phase == 0, "R11 reset levels", {env, phase}, 0);
    rst_n = 1;

    // R1: divided bit clock shape
    repeat (40) @(negedge clk);
    chk(last_period == DIV, "R1 bit clock period", last_period, DIV);
    highs = 0;
    for (int i = 0; i < 2 * DIV; i++) begin
      @(negedge clk);
      if (bitclk_out) highs++;
    end
    chk(highs == DIV, "R1 bit clock high time", highs, DIV);

    // table walk: one burst of eight dibits
    send_bit(0, 0);
    send_bit(1, 0);
    base = ngot;
    for (int i = 0; i < 8; i++) begin
      send_bit(VEC[i][4], 1);
      send_bit(VEC[i][3], 1);
    end
    send_bit(0, 0);
    send_bit(0, 0);
    flush();
    chk(ngot - base == 8, "R4 symbol count", ngot - base, 8);
    for (int i = 0; i < 8; i++)
      chk(got_ph[base + i] == int'(VEC[i][2:0]), (i == 0) ? "R6 first phase" : "R5 phase",
          got_ph[base + i], int'(VEC[i][2:0]));
    chk(rise_obs == e_rise + DLY, "R7 burst latency", rise_obs - e_rise, DLY);
    check_envelope();

    // directed: ignored bits, phase restart, odd trailing bit
    send_bit(1, 0);
    send_bit(1, 0);
    send_bit(1, 0);
    base = ngot;
    send_bit(1, 1); send_bit(1, 1);
    send_bit(1, 1); send_bit(0, 1);
    send_bit(1, 1);
    send_bit(0, 0);
    send_bit(0, 0);
    flush();
    chk(ngot - base == 2, "R4 odd bit dropped", ngot - base, 2);
    chk(got_ph[base] == 5, "R6 phase restart", got_ph[base], 5);
    chk(got_ph[base + 1] == 4, "R5 second step", got_ph[base + 1], 4);
    check_envelope();

    // directed: pass mode with external bit clock
    rst_n = 0;
    div_mode = 0;
    gen_on = 1;
    repeat (5) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk(bitclk_out == bitclk_in, "R2 pass-through", bitclk_out, bitclk_in);
    end
    base = ngot;
    send_bit(0, 1); send_bit(1, 1);
    send_bit(0, 1); send_bit(1, 1);
    send_bit(0, 1); send_bit(0, 1);
    send_bit(0, 0);
    send_bit(0, 0);
    flush();
    chk(ngot - base == 3, "R4 pass-mode count", ngot - base, 3);
    chk(got_ph[base] == 3, "R5 pass-mode phase 0", got_ph[base], 3);
    chk(got_ph[base + 1] == 6, "R5 pass-mode phase 1", got_ph[base + 1], 6);
    chk(got_ph[base + 2] == 7, "R5 pass-mode phase 2", got_ph[base + 2], 7);
    chk(rise_obs == e_rise + DLY, "R7 pass-mode burst latency", rise_obs - e_rise, DLY);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(WD * 10);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule